// File: doc/BRIEF.md
# Floppy Data Rate and Precompensation Select Register

This block is the write-only rate select register of a floppy disk controller. A host write of one byte sets the serial data rate, picks a write precompensation delay, can request manual low power, and can fire a software reset. The block turns the stored fields into outputs for the rest of the controller. These are the active rate code, a precompensation delay as an integer count of time steps, a low-power flag, and a one-clock reset pulse.

A separate configuration control register can also set the data rate. Whichever of the two registers was written most recently decides the active rate. Any access to the controller's data or main status register ends manual low power. A shadow copy of the register is always readable so that configuration software can see what was programmed.

The precompensation delay is counted in steps of 1/24 us below 2 Mbps and in steps of 1/48 us at 2 Mbps. The rate code that means 2 Mbps is set by a parameter.

Top module: `fdc_rate_sel`

## Requirements
- R1: After hardware reset the outputs are as follows: `rate_o` is 2, `lowpwr_o` is 0, `sw_rst_o` is 0, `shadow_o` is 8'h02 and `precomp_dly_o` is 3.
- R2: A host write (`dsr_we_i`) stores data bits 1:0 as the rate and bits 4:2 as the precompensation code. From the next clock these appear in `shadow_o` bits 1:0 and 4:2, and `rate_o` takes bits 1:0.
- R3: `shadow_o` bit 5 and bit 7 always read 0, whatever was written to those bits.
- R4: A host write with bit 7 set makes `sw_rst_o` high for the one clock that follows the write. The other fields of that write are still stored. The pulse does not change the stored rate or precompensation code.
- R5: A configuration register write (`ccr_we_i`) sets `rate_o` to `ccr_rate_i` on the next clock and leaves `shadow_o` unchanged. If both registers are written in the same cycle, the host write sets the rate.
- R6: Low power and its flag `lowpwr_o`:
  - A host write with bit 6 set and bit 7 clear sets `lowpwr_o`.
  - A host write with bit 7 set leaves `lowpwr_o` clear.
  - A data or status access (`data_acc_i`, `stat_acc_i`) with no host write in the same cycle clears `lowpwr_o`.
  - `shadow_o` bit 6 equals `lowpwr_o`.
- R7: When `rate_o` is not 3, the delay depends on the precompensation code:
  - Codes 1 to 6 give `precomp_dly_o` equal to the code, in 41.67 ns steps.
  - Code 7 gives 0.
  - Code 0 gives the slow default of 3 (125 ns).
- R8: When `rate_o` is 3 (the 2 Mbps code), the delay depends on the precompensation code:
  - Codes 1 to 6 give the code, in 20.8 ns steps.
  - Code 7 gives 0.
  - Code 0 gives the fast default of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| dsr_we_i | input | 1 | Host write strobe for this register |
| dsr_wdata_i | input | 8 | Host write data |
| ccr_we_i | input | 1 | Configuration control register write strobe |
| ccr_rate_i | input | 2 | Rate field of the configuration register write |
| data_acc_i | input | 1 | Data register access strobe |
| stat_acc_i | input | 1 | Main status register access strobe |
| rate_o | output | 2 | Active data rate code |
| precomp_dly_o | output | 3 | Precompensation delay in rate-dependent steps |
| lowpwr_o | output | 1 | Manual low power active |
| sw_rst_o | output | 1 | One-clock software reset pulse |
| shadow_o | output | 8 | Readable shadow copy of the register |

## Verification
Random cycles mix host writes, configuration writes and access strobes, often in the same cycle. This separates the last-writer rule for the rate from a fixed priority and shows which event wins for the low-power flag. Directed writes step through every precompensation code at a slow rate and at the 2 Mbps rate. They tell the two delay tables and their code-0 defaults apart. Back-to-back writes with bit 7 set, and a write with bits 7, 6 and 5 all set, separate the self-clearing pulse from a stored bit and from low-power entry.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int unsigned RATE_W = 2;
  localparam int unsigned PC_W   = 3;
  localparam int unsigned DLY_W  = 3;
  localparam logic [RATE_W-1:0] RATE_RST = 2'd2;
  localparam logic [PC_W-1:0]   PC_RST   = 3'd0;
  localparam logic [PC_W-1:0]   PC_ZERO  = 3'd7;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [PC_W-1:0]   pc;
    logic              lp;
  } rate_fields_t;
endpackage

// File: rtl/fdc_rate_store.sv
module fdc_rate_store
  import fdc_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dsr_we_i,
  input  logic [7:0]        dsr_wdata_i,
  input  logic              ccr_we_i,
  input  logic [RATE_W-1:0] ccr_rate_i,
  input  logic              acc_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              lp_o,
  output logic              sw_rst_o,
  output logic [7:0]        shadow_o
);
  rate_fields_t      dsr_q;
  logic [RATE_W-1:0] rate_q;
  logic              sw_q;
  logic              unused_bit5;

  assign unused_bit5 = dsr_wdata_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsr_q  <= '{rate: RATE_RST, pc: PC_RST, lp: 1'b0};
      rate_q <= RATE_RST;
      sw_q   <= 1'b0;
    end else begin
      sw_q <= dsr_we_i & dsr_wdata_i[7];
      if (dsr_we_i) begin
        dsr_q.rate <= dsr_wdata_i[1:0];
        dsr_q.pc   <= dsr_wdata_i[4:2];
        dsr_q.lp   <= dsr_wdata_i[6] & ~dsr_wdata_i[7]; // reset ends low power
        rate_q     <= dsr_wdata_i[1:0];
      end else begin
        if (ccr_we_i) rate_q   <= ccr_rate_i;
        if (acc_i)    dsr_q.lp <= 1'b0;
      end
    end
  end

  assign rate_o   = rate_q;
  assign pc_o     = dsr_q.pc;
  assign lp_o     = dsr_q.lp;
  assign sw_rst_o = sw_q;
  assign shadow_o = {1'b0, dsr_q.lp, 1'b0, dsr_q.pc, dsr_q.rate};

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_o && !(dsr_we_i && dsr_wdata_i[7])) |=> !sw_rst_o);
  a_r4_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |-> $past(dsr_we_i && dsr_wdata_i[7]));
  a_r5_ccr_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_we_i && !dsr_we_i) |=> (rate_o == $past(ccr_rate_i)));
  a_r6_access_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !dsr_we_i) |=> !lp_o);
  a_r2_shadow_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsr_we_i |=> (shadow_o[4:0] == $past(dsr_wdata_i[4:0])));
endmodule

// File: rtl/fdc_precomp_map.sv
module fdc_precomp_map
  import fdc_rate_pkg::*;
#(
  parameter logic [RATE_W-1:0] FAST_CODE = 2'd3,
  parameter int unsigned       DEF_SLOW  = 3,
  parameter int unsigned       DEF_FAST  = 1
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [DLY_W-1:0]  dly_o
);
  localparam logic [DLY_W-1:0] DefSlowQ = DLY_W'(DEF_SLOW);
  localparam logic [DLY_W-1:0] DefFastQ = DLY_W'(DEF_FAST);

  logic fast;
  assign fast = (rate_i == FAST_CODE);

  // codes 1..6 are the step count in either unit
  always_comb begin
    if (pc_i == PC_RST)       dly_o = fast ? DefFastQ : DefSlowQ;
    else if (pc_i == PC_ZERO) dly_o = '0;
    else                      dly_o = DLY_W'(pc_i);
  end
endmodule

// File: rtl/fdc_rate_sel.sv
module fdc_rate_sel
  import fdc_rate_pkg::*;
#(
  parameter logic [RATE_W-1:0] FAST_CODE = 2'd3,
  parameter int unsigned       DEF_SLOW  = 3,
  parameter int unsigned       DEF_FAST  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dsr_we_i,
  input  logic [7:0]        dsr_wdata_i,
  input  logic              ccr_we_i,
  input  logic [RATE_W-1:0] ccr_rate_i,
  input  logic              data_acc_i,
  input  logic              stat_acc_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [DLY_W-1:0]  precomp_dly_o,
  output logic              lowpwr_o,
  output logic              sw_rst_o,
  output logic [7:0]        shadow_o
);
  logic [PC_W-1:0] pc;

  fdc_rate_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dsr_we_i   (dsr_we_i),
    .dsr_wdata_i(dsr_wdata_i),
    .ccr_we_i   (ccr_we_i),
    .ccr_rate_i (ccr_rate_i),
    .acc_i      (data_acc_i | stat_acc_i),
    .rate_o     (rate_o),
    .pc_o       (pc),
    .lp_o       (lowpwr_o),
    .sw_rst_o   (sw_rst_o),
    .shadow_o   (shadow_o)
  );

  fdc_precomp_map #(
    .FAST_CODE(FAST_CODE),
    .DEF_SLOW (DEF_SLOW),
    .DEF_FAST (DEF_FAST)
  ) u_map (
    .rate_i(rate_o),
    .pc_i  (pc),
    .dly_o (precomp_dly_o)
  );

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsr_we_i |=> (shadow_o[7] == 1'b0 && shadow_o[5] == 1'b0));
  a_r6_shadow_lp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_o[6] == lowpwr_o);
endmodule

// File: tb/fdc_rate_sel_bench.sv
module fdc_rate_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dsr_we = 1'b0;
  logic [7:0] dsr_wdata = '0;
  logic       ccr_we = 1'b0;
  logic [1:0] ccr_rate = '0;
  logic       data_acc = 1'b0;
  logic       stat_acc = 1'b0;
  logic [1:0] rate;
  logic [2:0] dly;
  logic       lowpwr;
  logic       sw_rst;
  logic [7:0] shadow;

  int n_cmp = 0;
  int n_bad = 0;

  logic [1:0] m_rate, m_drate;
  logic [2:0] m_pc;
  logic       m_lp, m_sw;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_rate_sel u_fdc_rate_sel (
    .clk_i(clk), .rst_ni(rst_n), .dsr_we_i(dsr_we), .dsr_wdata_i(dsr_wdata),
    .ccr_we_i(ccr_we), .ccr_rate_i(ccr_rate), .data_acc_i(data_acc),
    .stat_acc_i(stat_acc), .rate_o(rate), .precomp_dly_o(dly),
    .lowpwr_o(lowpwr), .sw_rst_o(sw_rst), .shadow_o(shadow)
  );

  function automatic logic [2:0] exp_dly(input logic [1:0] r, input logic [2:0] c);
    if (c == 3'd0) return (r == 2'd3) ? 3'd1 : 3'd3;
    if (c == 3'd7) return 3'd0;
    return c;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R5 rate_o", rate, m_rate);
    cmp((m_rate == 2'd3) ? "R8 delay" : "R7 delay", dly, exp_dly(m_rate, m_pc));
    cmp("R6 lowpwr_o", lowpwr, m_lp);
    cmp("R4 sw_rst_o", sw_rst, m_sw);
    cmp("R2 R3 shadow_o", shadow, {1'b0, m_lp, 1'b0, m_pc, m_drate});
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic cw,
                      input logic [1:0] cr, input logic da, input logic sa);
    dsr_we = we; dsr_wdata = d; ccr_we = cw; ccr_rate = cr;
    data_acc = da; stat_acc = sa;
    @(posedge clk);
    m_sw = we & d[7];
    if (we) begin
      m_drate = d[1:0]; m_pc = d[4:2]; m_rate = d[1:0]; m_lp = d[6] & ~d[7];
    end else begin
      if (cw) m_rate = cr;
      if (da | sa) m_lp = 1'b0;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_rate = 2'd2; m_drate = 2'd2; m_pc = 3'd0; m_lp = 1'b0; m_sw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 rate_o", rate, 2);
    cmp("R1 delay", dly, 3);
    cmp("R1 lowpwr_o", lowpwr, 0);
    cmp("R1 sw_rst_o", sw_rst, 0);
    cmp("R1 shadow_o", shadow, 8'h02);

    // R7 / R8: sweep every code at a slow and the fast rate
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        step(1'b1, {3'b000, 3'(c), 2'(r)}, 1'b0, 2'd0, 1'b0, 1'b0);

    // R3: reserved bits written high, R4 back-to-back reset writes
    step(1'b1, 8'hE5, 1'b0, 2'd0, 1'b0, 1'b0);
    step(1'b1, 8'h80, 1'b0, 2'd0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0);
    // R6: enter low power, exit via status access
    step(1'b1, 8'h4D, 1'b0, 2'd0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    // R6: write wins over a same-cycle data access
    step(1'b1, 8'h40, 1'b0, 2'd0, 1'b1, 1'b0);
    // R5: config write overrides rate, then a same-cycle clash
    step(1'b0, 8'h00, 1'b1, 2'd3, 1'b0, 1'b0);
    step(1'b1, 8'h01, 1'b1, 2'd2, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b0);

    for (int i = 0; i < 600; i++)
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0,
           2'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule